// File: doc/BRIEF.md
# Microprocessor Host Bus Slave (8-bit, multiplexed or separated addressing)

This block connects an internal register file to the bus of an external 8-bit microprocessor. It runs on a fast system clock. Every bus input is asynchronous to that clock, so each one passes through a two-flop synchronizer before its edges are detected. The address is latched when the address-latch-enable input falls. It comes either from the shared address/data bus or from a dedicated address bus, depending on a mode input.

A second mode input selects the strobe style. In Intel style, separate read and write strobes are used. In Motorola style, a single data strobe is qualified by a read/write direction line. A read opens a window in which the block drives the contents of the addressed register. The tri-state bus is modelled as a data value plus an output enable. A write is committed on the rising edge of the write strobe.

Toward the register file, the block produces a held address, a one-cycle read strobe at the start of each read window, and a one-cycle write strobe with its data. Registers with read side effects are therefore read once per bus cycle.

Top module: `hbus_slave`

## Requirements
- R1: While reset is active and afterwards until a bus cycle occurs: `ad_oe`=0, `reg_rd`=0, `reg_wr`=0, `reg_addr`=0 and `ad_out`=0.
- R2: With `mode_sep`=0, a falling edge of `ale` latches `ad_in` into `reg_addr`. The new address is visible after the third rising clock edge following the fall, and `reg_addr` changes at no other time.
- R3: With `mode_sep`=1, a falling edge of `ale` latches `addr_in` into `reg_addr`, and the value on `ad_in` at that time has no effect.
- R4: In Intel style (`mode_moto`=0), once `cs_n` and `rd_n` are both low, `reg_rd` pulses after the third clock edge. One edge later, `ad_oe`=1 and `ad_out` holds the value `reg_rdata` had while `reg_rd` was high.
- R5: A read window ends on the rising edge of either chip select or the read strobe. `ad_oe` returns to 0 after the third clock edge following that rise.
- R6: Exactly one `reg_rd` pulse, one clock long, is produced per read window, however long the window lasts.
- R7: In Intel style, a rising edge of `wr_n` that ends a period with `cs_n` and `wr_n` both low produces one `reg_wr` pulse, one clock long, after the third clock edge. `reg_wdata` carries the `ad_in` value held while the strobe was low, and `reg_addr` carries the latched address.
- R8: In Motorola style (`mode_moto`=1), a read window is `cs_n`=0, `ds_n`=0 with `rw`=1 (1 = read), and the timing of R4–R6 applies.
- R9: In Motorola style, a rising edge of `ds_n` that ends a period with `cs_n`=0, `ds_n`=0 and `rw`=0 commits a write as in R7. This holds even when `cs_n` rises on the same edge.
- R10: The strobes of the unselected style are ignored. In Intel style, `ds_n` and `rw` cause no read, no write and no drive. In Motorola style, `rd_n` and `wr_n` cause none of these.
- R11: With `cs_n` high, strobe activity produces no `reg_rd`, no `reg_wr` and no `ad_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sep | input | 1 | 0 = address taken from `ad_in`, 1 = address taken from `addr_in` |
| mode_moto | input | 1 | 0 = Intel strobes (`rd_n`/`wr_n`), 1 = Motorola strobes (`ds_n` with `rw`) |
| cs_n | input | 1 | Chip select, active low |
| ale | input | 1 | Address latch enable; address captured on its falling edge |
| rd_n | input | 1 | Intel read strobe, active low |
| wr_n | input | 1 | Intel write strobe, active low |
| ds_n | input | 1 | Motorola data strobe, active low |
| rw | input | 1 | Motorola direction: 1 = read, 0 = write |
| ad_in | input | 8 | Address/data bus input |
| addr_in | input | 8 | Dedicated address bus for separated mode |
| ad_out | output | 8 | Read data driven onto the bus |
| ad_oe | output | 1 | Bus output enable |
| reg_addr | output | 8 | Latched register address |
| reg_rd | output | 1 | One-cycle register read strobe |
| reg_rdata | input | 8 | Register file read data for `reg_addr` |
| reg_wr | output | 1 | One-cycle register write strobe |
| reg_wdata | output | 8 | Register write data |

## Verification
Each result lands a fixed number of clock edges after the bus input that causes it. Two edges go to the synchronizer and one to the output register, so the latched address, the read pulse, the release of the output enable and the write pulse are all due after the third rising edge. The enable and the read data come one edge later, because they capture the register file's answer to the read pulse. The bench drives inputs on falling edges and samples on falling edges. It checks each result at its exact due edge, and also one edge early or one edge late where that shows the pulse shape or the timing. Read and write pulses are also counted on every rising edge, so that a bus cycle that should do nothing is shown to have produced no strobe at all.

// File: rtl/hbus_pkg.sv
// Package: shared types for the host bus slave.
// Assumes an 8-bit data path; widths are carried as parameters elsewhere.
package hbus_pkg;

    // Selects where the register address is taken from.
    typedef enum logic {
        ADDR_SHARED = 1'b0,
        ADDR_DEDICATED = 1'b1
    } addr_src_e;

    // Selects the strobe protocol on the bus.
    typedef enum logic {
        STB_INTEL = 1'b0,
        STB_MOTO = 1'b1
    } strobe_style_e;

    // Synchronized control lines, packed for one synchronizer instance.
    typedef struct packed {
        logic cs_n;
        logic ale;
        logic rd_n;
        logic wr_n;
        logic ds_n;
        logic rw;
    } bus_ctl_t;

    localparam int CTL_W = $bits(bus_ctl_t);

    // Idle level of each control line, used as the synchronizer reset value.
    localparam bus_ctl_t CTL_IDLE = '{cs_n: 1'b1, ale: 1'b0, rd_n: 1'b1,
                                      wr_n: 1'b1, ds_n: 1'b1, rw: 1'b1};

endpackage

// File: rtl/hbus_sync.sv
// Module: hbus_sync
// Multi-stage flop synchronizer for a vector of asynchronous inputs.
// Assumes multi-bit buses are stable around the control edges that use them,
// so bit skew between the bits of a bus is harmless.
module hbus_sync #(
    parameter int W = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                // Purpose: first capture of the asynchronous input.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[0] <= RST_VAL;
                    else        stg[0] <= d;
                end
            end else begin : g_next
                // Purpose: further settling stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[i] <= RST_VAL;
                    else        stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/hbus_addr_latch.sv
// Module: hbus_addr_latch
// Detects the falling edge of the synchronized address-latch-enable and
// captures the register address from the shared or the dedicated bus.
// Assumes the selected bus holds the address for a cycle after the fall.
module hbus_addr_latch
    import hbus_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  addr_src_e     src,
    input  logic          ale_s,
    input  logic [AW-1:0] shared_s,
    input  logic [AW-1:0] dedicated_s,
    output logic [AW-1:0] addr_q
);

    logic ale_p;
    logic ale_fall;
    logic [AW-1:0] addr_sel;

    // Purpose: remember the previous synchronized ALE level.
    always_ff @(posedge clk) begin
        if (!rst_n) ale_p <= 1'b0;
        else        ale_p <= ale_s;
    end

    assign ale_fall = ale_p & ~ale_s;

    // Purpose: pick the address source for the current mode.
    always_comb begin
        if (src == ADDR_DEDICATED) addr_sel = dedicated_s;
        else                       addr_sel = shared_s;
    end

    // Purpose: capture the address on the ALE falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n)        addr_q <= '0;
        else if (ale_fall) addr_q <= addr_sel;
    end

    // R2: the address only moves after an ALE fall.
    p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ale_fall |=> $stable(addr_q));

endmodule

// File: rtl/hbus_ctrl.sv
// Module: hbus_ctrl
// Decodes the synchronized strobes for the selected style. It opens and
// closes read windows, drives read data, and commits writes on the rising
// strobe edge. Assumes the direction line is stable across a strobe window.
module hbus_ctrl
    import hbus_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  strobe_style_e style,
    input  logic          cs_n_s,
    input  logic          rd_n_s,
    input  logic          wr_n_s,
    input  logic          ds_n_s,
    input  logic          rw_s,
    input  logic [DW-1:0] data_s,
    input  logic [DW-1:0] rdata,
    output logic [DW-1:0] bus_out,
    output logic          bus_oe,
    output logic          rd_pulse,
    output logic          wr_pulse,
    output logic [DW-1:0] wdata
);

    logic rd_low, rd_dir, rd_active, rd_win;
    logic wr_low, wr_dir, wr_armed, wr_armed_p, commit;
    logic [DW-1:0] data_p;

    // Purpose: read strobe level and direction for the selected style.
    always_comb begin
        if (style == STB_MOTO) begin
            rd_low = ~ds_n_s;
            rd_dir = rw_s;
            wr_low = ~ds_n_s;
            wr_dir = ~rw_s;
        end else begin
            rd_low = ~rd_n_s;
            rd_dir = 1'b1;
            wr_low = ~wr_n_s;
            wr_dir = 1'b1;
        end
    end

    assign rd_active = ~cs_n_s & rd_low & rd_dir;
    assign wr_armed  = ~cs_n_s & wr_low & wr_dir;
    assign commit    = wr_armed_p & ~wr_low;

    // Purpose: track the read window and issue a single read pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_win   <= 1'b0;
            rd_pulse <= 1'b0;
        end else begin
            rd_win   <= rd_active;
            rd_pulse <= rd_active & ~rd_win;
        end
    end

    // Purpose: capture read data after the pulse and drive while open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_out <= '0;
            bus_oe  <= 1'b0;
        end else begin
            bus_oe <= rd_active & rd_win;
            if (rd_pulse) bus_out <= rdata;
        end
    end

    // Purpose: hold last-cycle write qualification and bus data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_armed_p <= 1'b0;
            data_p     <= '0;
        end else begin
            wr_armed_p <= wr_armed;
            data_p     <= data_s;
        end
    end

    // Purpose: commit a write on the rising strobe edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_pulse <= 1'b0;
            wdata    <= '0;
        end else begin
            wr_pulse <= commit;
            if (commit) wdata <= data_p;
        end
    end

    // R6: the read strobe is never longer than one cycle.
    p_rd_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pulse |=> !rd_pulse);

    // R7: the write strobe is never longer than one cycle.
    p_wr_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !wr_pulse);

    // R4: the bus is driven only inside an open read window.
    p_oe_in_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> rd_win);

    // R5: once the read condition is gone, the drivers release next cycle.
    p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_active |=> !bus_oe);

endmodule

// File: rtl/hbus_slave.sv
// Module: hbus_slave (top)
// 8-bit microprocessor bus slave with selectable address mode and strobe
// style. It synchronizes all bus inputs and presents single-cycle register
// strobes. Assumes reg_rdata answers reg_addr combinationally.
module hbus_slave
    import hbus_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_sep,
    input  logic          mode_moto,
    input  logic          cs_n,
    input  logic          ale,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic          ds_n,
    input  logic          rw,
    input  logic [DW-1:0] ad_in,
    input  logic [AW-1:0] addr_in,
    output logic [DW-1:0] ad_out,
    output logic          ad_oe,
    output logic [AW-1:0] reg_addr,
    output logic          reg_rd,
    input  logic [DW-1:0] reg_rdata,
    output logic          reg_wr,
    output logic [DW-1:0] reg_wdata
);

    localparam int BUS_W = DW + AW;

    bus_ctl_t ctl_raw, ctl_s;
    logic [BUS_W-1:0] bus_raw, bus_s;
    addr_src_e src;
    strobe_style_e style;

    assign ctl_raw = '{cs_n: cs_n, ale: ale, rd_n: rd_n, wr_n: wr_n,
                       ds_n: ds_n, rw: rw};
    assign bus_raw = {addr_in, ad_in};
    assign src     = addr_src_e'(mode_sep);
    assign style   = strobe_style_e'(mode_moto);

    hbus_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) u_ctl_sync (
        .clk(clk), .rst_n(rst_n), .d(ctl_raw), .q(ctl_s)
    );

    hbus_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_sync (
        .clk(clk), .rst_n(rst_n), .d(bus_raw), .q(bus_s)
    );

    hbus_addr_latch #(.AW(AW)) u_addr (
        .clk(clk), .rst_n(rst_n), .src(src), .ale_s(ctl_s.ale),
        .shared_s(bus_s[AW-1:0]), .dedicated_s(bus_s[BUS_W-1:DW]),
        .addr_q(reg_addr)
    );

    hbus_ctrl #(.DW(DW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .style(style),
        .cs_n_s(ctl_s.cs_n), .rd_n_s(ctl_s.rd_n), .wr_n_s(ctl_s.wr_n),
        .ds_n_s(ctl_s.ds_n), .rw_s(ctl_s.rw), .data_s(bus_s[DW-1:0]),
        .rdata(reg_rdata), .bus_out(ad_out), .bus_oe(ad_oe),
        .rd_pulse(reg_rd), .wr_pulse(reg_wr), .wdata(reg_wdata)
    );

endmodule

// File: tb/hbus_slave_test.sv
module hbus_slave_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_sep = 1'b0, mode_moto = 1'b0;
    logic cs_n = 1'b1, ale = 1'b0, rd_n = 1'b1, wr_n = 1'b1, ds_n = 1'b1, rw = 1'b1;
    logic [7:0] ad_in = 8'h00, addr_in = 8'h00;
    logic [7:0] ad_out, reg_addr, reg_rdata, reg_wdata;
    logic ad_oe, reg_rd, reg_wr;
    int total = 0, fails = 0, rd_cnt = 0, wr_cnt = 0;

    always #10 clk = ~clk;

    assign reg_rdata = reg_addr ^ 8'hA5;

    hbus_slave uut (
        .clk(clk), .rst_n(rst_n), .mode_sep(mode_sep), .mode_moto(mode_moto),
        .cs_n(cs_n), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .ds_n(ds_n), .rw(rw),
        .ad_in(ad_in), .addr_in(addr_in), .ad_out(ad_out), .ad_oe(ad_oe),
        .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata)
    );

    always @(posedge clk) begin
        if (rst_n && reg_rd) rd_cnt <= rd_cnt + 1;
        if (rst_n && reg_wr) wr_cnt <= wr_cnt + 1;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    // Address phase: ALE high then low; address on the bus of the current mode.
    task automatic addr_phase(input logic [7:0] a, input logic [7:0] junk);
        if (mode_sep) begin addr_in = a; ad_in = junk; end
        else          begin ad_in = a; addr_in = junk; end
        ale = 1'b1;
        tick(4);
        ale = 1'b0;
        tick(3);
    endtask

    task automatic t_reset;
        check("R1 ad_oe", ad_oe, 0);
        check("R1 reg_rd", reg_rd, 0);
        check("R1 reg_wr", reg_wr, 0);
        check("R1 reg_addr", reg_addr, 0);
        check("R1 ad_out", ad_out, 0);
    endtask

    task automatic t_mux_addr(input logic [7:0] a);
        mode_sep = 1'b0;
        addr_phase(a, ~a);
        check("R2 addr latched", reg_addr, a);
        ad_in = 8'h3C; tick(5);
        check("R2 addr held", reg_addr, a);
    endtask

    task automatic t_sep_addr(input logic [7:0] a);
        mode_sep = 1'b1;
        addr_phase(a, 8'hEE);
        check("R3 dedicated addr", reg_addr, a);
        mode_sep = 1'b0;
    endtask

    // Read in the current style; release via chip select or via strobe.
    task automatic t_read(input logic [7:0] a, input bit via_cs, input string req);
        int c0;
        addr_phase(a, 8'h00);
        c0 = rd_cnt;
        cs_n = 1'b0;
        if (mode_moto) begin rw = 1'b1; ds_n = 1'b0; end
        else           rd_n = 1'b0;
        tick(2);
        check({req, " no early rd"}, reg_rd, 0);
        tick(1);
        check({req, " rd pulse"}, reg_rd, 1);
        check({req, " oe not yet"}, ad_oe, 0);
        tick(1);
        check({req, " rd pulse ends"}, reg_rd, 0);
        check({req, " oe on"}, ad_oe, 1);
        check({req, " data"}, ad_out, a ^ 8'hA5);
        tick(6);
        check("R6 one rd pulse", rd_cnt - c0, 1);
        if (via_cs) cs_n = 1'b1;
        else if (mode_moto) ds_n = 1'b1;
        else rd_n = 1'b1;
        tick(2);
        check("R5 oe still on", ad_oe, 1);
        tick(1);
        check("R5 oe released", ad_oe, 0);
        cs_n = 1'b1; rd_n = 1'b1; ds_n = 1'b1;
        tick(4);
        check("R6 no rd on release", rd_cnt - c0, 1);
    endtask

    // Write in the current style; cs may rise together with the strobe.
    task automatic t_write(input logic [7:0] a, input logic [7:0] d,
                           input bit cs_together, input string req);
        int c0;
        addr_phase(a, 8'h00);
        c0 = wr_cnt;
        ad_in = d;
        if (mode_moto) begin rw = 1'b0; tick(1); end
        cs_n = 1'b0;
        if (mode_moto) ds_n = 1'b0; else wr_n = 1'b0;
        tick(5);
        check({req, " no early wr"}, reg_wr, 0);
        if (mode_moto) ds_n = 1'b1; else wr_n = 1'b1;
        if (cs_together) cs_n = 1'b1;
        tick(2);
        check({req, " wr not yet"}, reg_wr, 0);
        tick(1);
        check({req, " wr pulse"}, reg_wr, 1);
        check({req, " wdata"}, reg_wdata, d);
        check({req, " waddr"}, reg_addr, a);
        ad_in = 8'h00;
        tick(1);
        check({req, " wr one cycle"}, reg_wr, 0);
        cs_n = 1'b1;
        if (mode_moto) begin tick(1); rw = 1'b1; end
        tick(4);
        check({req, " one wr"}, wr_cnt - c0, 1);
        check({req, " no oe on write"}, ad_oe, 0);
    endtask

    task automatic t_other_style_ignored;
        int r0, w0;
        r0 = rd_cnt; w0 = wr_cnt;
        mode_moto = 1'b0;
        cs_n = 1'b0;
        rw = 1'b0; ds_n = 1'b0; tick(6);
        check("R10 intel ignores ds oe", ad_oe, 0);
        ds_n = 1'b1; tick(6); rw = 1'b1;
        rw = 1'b1; ds_n = 1'b0; tick(6); ds_n = 1'b1; tick(6);
        cs_n = 1'b1; tick(2);
        check("R10 intel ignores ds/rw", (rd_cnt - r0) + (wr_cnt - w0), 0);
        mode_moto = 1'b1;
        cs_n = 1'b0;
        rd_n = 1'b0; tick(6);
        check("R10 moto ignores rd_n oe", ad_oe, 0);
        rd_n = 1'b1; wr_n = 1'b0; tick(6); wr_n = 1'b1; tick(6);
        cs_n = 1'b1; tick(2);
        check("R10 moto ignores rd_n/wr_n", (rd_cnt - r0) + (wr_cnt - w0), 0);
        mode_moto = 1'b0;
    endtask

    task automatic t_no_cs;
        int r0, w0;
        r0 = rd_cnt; w0 = wr_cnt;
        cs_n = 1'b1;
        rd_n = 1'b0; tick(6);
        check("R11 no oe without cs", ad_oe, 0);
        rd_n = 1'b1; wr_n = 1'b0; tick(6); wr_n = 1'b1; tick(6);
        check("R11 no strobes without cs", (rd_cnt - r0) + (wr_cnt - w0), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        tick(3);
        t_reset();
        rst_n = 1'b1;
        tick(3);
        t_reset();
        t_mux_addr(8'h5A);
        t_mux_addr(8'hC3);
        t_sep_addr(8'h81);
        t_read(8'h12, 1'b0, "R4");
        t_read(8'h7E, 1'b1, "R4 cs release");
        t_write(8'h40, 8'h9D, 1'b0, "R7");
        mode_sep = 1'b1;
        t_write(8'h41, 8'h26, 1'b0, "R7 sep");
        mode_sep = 1'b0;
        mode_moto = 1'b1;
        t_read(8'h33, 1'b0, "R8");
        t_write(8'hA0, 8'h5F, 1'b1, "R9");
        mode_moto = 1'b0;
        t_other_style_ignored();
        t_no_cs();
        summary();
    end

endmodule